// File: doc/BRIEF.md
# Byte Arithmetic/Logic Unit with Working and Flag Registers

This block is the execution stage of a small accumulator-style processor. It holds an 8-bit working register and an 8-bit flag register. Each valid operation combines the working register with a second operand, which comes either from a data-memory word presented by the surrounding core or from an immediate byte. The result goes either back into the working register or out to the data memory through a write strobe.

The flag register holds carry, half (nibble) carry and zero. Two more bits report a timer expiry and a power-down event; operations cannot change them. The three upper bits are plain storage. When the flag register itself is the target of an operation, a masking rule applies. For any operation that updates arithmetic flags, the flag logic keeps control of the three low bits and the data only fills the upper storage bits. The core drives a select bit to name the flag register as the target, so the block itself does no address decode.

Opcodes (4-bit `opCode`): 0 move operand, 1 add, 2 subtract, 3 AND, 4 OR, 5 XOR, 6 complement, 7 increment, 8 decrement, 9 rotate left through carry, 10 rotate right through carry, 11 nibble swap, 12 clear, 13 bit set, 14 bit clear, 15 move working register.

Top module: `alu_status_unit`

## Requirements
- R1: After reset the working register reads 0x00 and the flag register reads 0x18. The flag register layout is carry at bit 0, half carry at bit 1, zero at bit 2, power-down at bit 3, time-out at bit 4, and plain storage at bits 7:5.
- R2: Add (opCode 1) gives (W + operand) mod 256. Carry is the carry out of bit 7, half carry is the carry out of bit 3, and zero is set when the result is 0.
- R3: Subtract (opCode 2) gives (operand - W) mod 256, computed as the operand plus the two's complement of W. Carry is 1 when operand >= W (no borrow). Half carry is 1 when operand[3:0] >= W[3:0]. Zero follows the result.
- R4: The following operations update only the zero flag: AND (3), OR (4), XOR (5), complement (6), increment (7), decrement (8), move operand (0) and clear (12). Carry and half carry keep their values.
- R5: Rotate left (9) shifts the old carry into bit 0 and loads carry with operand bit 7. Rotate right (10) shifts the old carry into bit 7 and loads carry with operand bit 0. Zero and half carry are unchanged.
- R6: Nibble swap (11), bit set (13), bit clear (14) and move W (15) change no flag. Bit set and bit clear act on the operand bit numbered by `bitSel`.
- R7: When `destIsFile` is 0, the result loads the working register and `fileWrEn` stays low. When it is 1 and `fileIsStatus` is 0, `fileWrEn` is high in the same cycle with the result on `fileWrData`, and W keeps its value.
- R8: When the flag register is the target of a flag-updating operation, bits 2:0 take the flag-logic values and ignore the data. Flags the operation does not touch keep their old value, so clear gives 000 u u 1 u u. Bits 7:5 take the result, and `fileWrEn` stays low.
- R9: When the flag register is the target of an operation that changes no flag, bits 7:5 and 2:0 take the result.
- R10: Power-down (bit 3) and time-out (bit 4) are never changed by any operation.
- R11: With `opValid` low, neither register changes and `fileWrEn` stays low.
- R12: `srcIsLiteral` = 1 selects `litData` as the operand and `srcIsLiteral` = 0 selects `fileData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe for this cycle |
| opCode | input | 4 | Operation code |
| srcIsLiteral | input | 1 | Operand select: 1 immediate, 0 memory word |
| fileData | input | 8 | Memory-word operand |
| litData | input | 8 | Immediate operand |
| bitSel | input | 3 | Bit number for bit set and bit clear |
| destIsFile | input | 1 | Result target: 0 working register, 1 memory/flag register |
| fileIsStatus | input | 1 | Memory target is the flag register |
| workReg | output | 8 | Working register |
| statusReg | output | 8 | Flag register |
| fileWrEn | output | 1 | Memory write strobe |
| fileWrData | output | 8 | Result, valid when fileWrEn is high |

## Verification
Add is swept over every operand byte against working-register values spread across the whole byte range. Subtract gets the same sweep with a denser set of W values, fed from the immediate path. These sweeps separate the bit-7 carry from the bit-3 carry and catch a borrow taken with the wrong sense. The Z-only operations run over all 256 operands with carry and half carry preset to 1, which exposes any operation that wrongly touches them. The rotates run over every byte with the carry chained from step to step. Swap, bit set and bit clear run over every bit number. Writes into the flag register, with flags preset both ways, separate the masked case from the plain data case.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int C_BIT  = 0;
  localparam int DC_BIT = 1;
  localparam int Z_BIT  = 2;
  localparam int PD_BIT = 3;
  localparam int TO_BIT = 4;

  typedef enum logic [3:0] {
    OP_MOVF = 4'd0,  OP_ADD  = 4'd1,  OP_SUB  = 4'd2,  OP_AND  = 4'd3,
    OP_IOR  = 4'd4,  OP_XOR  = 4'd5,  OP_COM  = 4'd6,  OP_INC  = 4'd7,
    OP_DEC  = 4'd8,  OP_RLC  = 4'd9,  OP_RRC  = 4'd10, OP_SWAP = 4'd11,
    OP_CLR  = 4'd12, OP_BSET = 4'd13, OP_BCLR = 4'd14, OP_MOVW = 4'd15
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic updZ;
    logic updC;
    logic updDc;
    logic loadW;
    logic writeFile;
    logic writeStatus;
  } aluCtrl_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic     opValid,
  input  aluOp_e   op,
  input  logic     destIsFile,
  input  logic     fileIsStatus,
  output aluCtrl_t ctrl
);
  logic zOp, cOp, dcOp;

  always_comb begin
    zOp  = 1'b0;
    cOp  = 1'b0;
    dcOp = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        zOp  = 1'b1;
        cOp  = 1'b1;
        dcOp = 1'b1;
      end
      OP_MOVF, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_INC, OP_DEC, OP_CLR:
        zOp = 1'b1;
      OP_RLC, OP_RRC:
        cOp = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    ctrl.updZ        = opValid & zOp;
    ctrl.updC        = opValid & cOp;
    ctrl.updDc       = opValid & dcOp;
    ctrl.loadW       = opValid & ~destIsFile;
    ctrl.writeFile   = opValid & destIsFile & ~fileIsStatus;
    ctrl.writeStatus = opValid & destIsFile & fileIsStatus;
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  aluOp_e            op,
  input  logic              srcIsLiteral,
  input  logic [DATA_W-1:0] fileData,
  input  logic [DATA_W-1:0] litData,
  input  logic [BIT_W-1:0]  bitSel,
  output logic [DATA_W-1:0] workReg,
  output logic [DATA_W-1:0] statusReg,
  output logic [DATA_W-1:0] result
);
  localparam int NIB = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'((1 << TO_BIT) | (1 << PD_BIT));
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'((1 << C_BIT) | (1 << DC_BIT) | (1 << Z_BIT));
  localparam logic [DATA_W-1:0] STATUS_RST = LOCK_MASK;

  logic [DATA_W-1:0] opB, addend, bitMask, flagVec, statusNext;
  logic [DATA_W:0]   sumFull;
  logic [NIB:0]      sumLow;
  logic              isSub, shiftOut, carryOut, anyUpd;

  assign opB = srcIsLiteral ? litData : fileData;

  // one-hot bit selector
  for (genvar g = 0; g < DATA_W; g++) begin : gMask
    assign bitMask[g] = (bitSel == BIT_W'(g));
  end

  // shared adder: subtract adds the inverted W plus one
  always_comb begin
    isSub   = (op == OP_SUB);
    addend  = isSub ? ~workReg : workReg;
    sumFull = {1'b0, opB} + {1'b0, addend} + {{DATA_W{1'b0}}, isSub};
    sumLow  = {1'b0, opB[NIB-1:0]} + {1'b0, addend[NIB-1:0]} + {{NIB{1'b0}}, isSub};
  end

  always_comb begin
    result   = opB;
    shiftOut = 1'b0;
    case (op)
      OP_MOVF: result = opB;
      OP_ADD,
      OP_SUB:  result = sumFull[DATA_W-1:0];
      OP_AND:  result = workReg & opB;
      OP_IOR:  result = workReg | opB;
      OP_XOR:  result = workReg ^ opB;
      OP_COM:  result = ~opB;
      OP_INC:  result = opB + DATA_W'(1);
      OP_DEC:  result = opB - DATA_W'(1);
      OP_RLC: begin
        result   = {opB[DATA_W-2:0], statusReg[C_BIT]};
        shiftOut = opB[DATA_W-1];
      end
      OP_RRC: begin
        result   = {statusReg[C_BIT], opB[DATA_W-1:1]};
        shiftOut = opB[0];
      end
      OP_SWAP: result = {opB[NIB-1:0], opB[DATA_W-1:NIB]};
      OP_CLR:  result = '0;
      OP_BSET: result = opB | bitMask;
      OP_BCLR: result = opB & ~bitMask;
      OP_MOVW: result = workReg;
      default: result = opB;
    endcase
  end

  always_comb begin
    carryOut = (op == OP_RLC || op == OP_RRC) ? shiftOut : sumFull[DATA_W];
    anyUpd   = ctrl.updZ | ctrl.updC | ctrl.updDc;
    flagVec  = statusReg;
    if (ctrl.updC)  flagVec[C_BIT]  = carryOut;
    if (ctrl.updDc) flagVec[DC_BIT] = sumLow[NIB];
    if (ctrl.updZ)  flagVec[Z_BIT]  = (result == '0);
    if (ctrl.writeStatus)
      statusNext = (result & ~LOCK_MASK & ~FLAG_MASK)
                 | (statusReg & LOCK_MASK)
                 | ((anyUpd ? flagVec : result) & FLAG_MASK);
    else
      statusNext = flagVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workReg   <= '0;
      statusReg <= STATUS_RST;
    end else begin
      if (ctrl.loadW) workReg <= result;
      statusReg <= statusNext;
    end
  end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic              srcIsLiteral,
  input  logic [DATA_W-1:0] fileData,
  input  logic [DATA_W-1:0] litData,
  input  logic [BIT_W-1:0]  bitSel,
  input  logic              destIsFile,
  input  logic              fileIsStatus,
  output logic [DATA_W-1:0] workReg,
  output logic [DATA_W-1:0] statusReg,
  output logic              fileWrEn,
  output logic [DATA_W-1:0] fileWrData
);
  aluOp_e   op;
  aluCtrl_t ctrl;

  assign op = aluOp_e'(opCode);

  alu_ctrl u_ctrl (
    .opValid      (opValid),
    .op           (op),
    .destIsFile   (destIsFile),
    .fileIsStatus (fileIsStatus),
    .ctrl         (ctrl)
  );

  alu_datapath #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .op           (op),
    .srcIsLiteral (srcIsLiteral),
    .fileData     (fileData),
    .litData      (litData),
    .bitSel       (bitSel),
    .workReg      (workReg),
    .statusReg    (statusReg),
    .result       (fileWrData)
  );

  assign fileWrEn = ctrl.writeFile;
endmodule

// File: rtl/alu_status_unit_chk.sv
module alu_status_unit_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic              destIsFile,
  input logic              fileIsStatus,
  input logic [DATA_W-1:0] workReg,
  input logic [DATA_W-1:0] statusReg,
  input logic              fileWrEn,
  input logic [DATA_W-1:0] fileWrData
);
  logic quietOp, zOnlyOp;
  assign quietOp = (opCode == OP_SWAP) || (opCode == OP_BSET) ||
                   (opCode == OP_BCLR) || (opCode == OP_MOVW);
  assign zOnlyOp = (opCode == OP_AND) || (opCode == OP_IOR) || (opCode == OP_XOR) ||
                   (opCode == OP_COM) || (opCode == OP_INC) || (opCode == OP_DEC) ||
                   (opCode == OP_MOVF) || (opCode == OP_CLR);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(workReg) && $stable(statusReg)));

  assert_lock_bits_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[TO_BIT] && statusReg[PD_BIT]);

  assert_file_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    fileWrEn |-> (opValid && destIsFile && !fileIsStatus));

  assert_w_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && destIsFile) |=> $stable(workReg));

  assert_quiet_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && quietOp && !(destIsFile && fileIsStatus)) |=> $stable(statusReg));

  assert_zero_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fileWrEn && zOnlyOp) |=>
      ((statusReg[Z_BIT] == ($past(fileWrData) == '0)) && $stable(statusReg[DC_BIT:C_BIT])));
endmodule

bind alu_status_unit alu_status_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .opValid      (opValid),
  .opCode       (opCode),
  .destIsFile   (destIsFile),
  .fileIsStatus (fileIsStatus),
  .workReg      (workReg),
  .statusReg    (statusReg),
  .fileWrEn     (fileWrEn),
  .fileWrData   (fileWrData)
);

// File: tb/sim_alu_status_unit.sv
module sim_alu_status_unit;
  import alu_pkg::*;

  logic       clk = 1'b0;
  logic       rstN, opValid, srcIsLiteral, destIsFile, fileIsStatus;
  logic [3:0] opCode;
  logic [7:0] fileData, litData;
  logic [2:0] bitSel;
  logic [7:0] workReg, statusReg, fileWrData;
  logic       fileWrEn;

  int testsRun = 0;
  int testsFailed = 0;
  int mW = 0;
  int mS = 'h18;

  always #4 clk = ~clk;

  alu_status_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcIsLiteral(srcIsLiteral), .fileData(fileData), .litData(litData),
    .bitSel(bitSel), .destIsFile(destIsFile), .fileIsStatus(fileIsStatus),
    .workReg(workReg), .statusReg(statusReg), .fileWrEn(fileWrEn),
    .fileWrData(fileWrData)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // arithmetic reference built from the requirements
  function automatic void model(input aluOp_e op, input int b, input int bs,
                                input bit dest, input bit stat,
                                output int res, output int nw, output int ns);
    int w = mW;
    int s = mS;
    int c = s & 1;
    int dc = (s >> 1) & 1;
    int z = (s >> 2) & 1;
    int flags;
    bit fz = 0, fc = 0, fdc = 0;
    res = b;
    case (op)
      OP_ADD: begin
        res = (w + b) % 256; c = (w + b > 255) ? 1 : 0;
        dc = ((w % 16) + (b % 16) > 15) ? 1 : 0; fz = 1; fc = 1; fdc = 1;
      end
      OP_SUB: begin
        res = (b - w + 256) % 256; c = (b >= w) ? 1 : 0;
        dc = ((b % 16) >= (w % 16)) ? 1 : 0; fz = 1; fc = 1; fdc = 1;
      end
      OP_AND:  begin res = w & b; fz = 1; end
      OP_IOR:  begin res = w | b; fz = 1; end
      OP_XOR:  begin res = w ^ b; fz = 1; end
      OP_COM:  begin res = 255 - b; fz = 1; end
      OP_INC:  begin res = (b + 1) % 256; fz = 1; end
      OP_DEC:  begin res = (b + 255) % 256; fz = 1; end
      OP_MOVF: begin res = b; fz = 1; end
      OP_CLR:  begin res = 0; fz = 1; end
      OP_RLC:  begin res = (b * 2) % 256 + c; c = (b >= 128) ? 1 : 0; fc = 1; end
      OP_RRC:  begin res = b / 2 + c * 128; c = b % 2; fc = 1; end
      OP_SWAP: res = (b % 16) * 16 + b / 16;
      OP_BSET: res = b | (1 << bs);
      OP_BCLR: res = b & ~(1 << bs) & 255;
      OP_MOVW: res = w;
      default: res = b;
    endcase
    if (fz) z = (res == 0) ? 1 : 0;
    flags = z * 4 + dc * 2 + c;
    if (dest && stat)
      ns = (res & 'hE0) | (s & 'h18) | ((fz || fc || fdc) ? flags : (res & 7));
    else
      ns = (s & 'hF8) | flags;
    nw = dest ? w : res;
  endfunction

  task automatic step(input aluOp_e op, input bit lit, input int fv, input int lv,
                      input int bs, input bit dest, input bit stat, input string req);
    int res, nw, ns;
    @(negedge clk);
    opValid = 1'b1; opCode = op; srcIsLiteral = lit;
    fileData = fv[7:0]; litData = lv[7:0]; bitSel = bs[2:0];
    destIsFile = dest; fileIsStatus = stat;
    model(op, lit ? lv : fv, bs, dest, stat, res, nw, ns);
    #1;
    if (dest && !stat)
      check(fileWrEn && fileWrData == res[7:0], req, {fileWrEn, fileWrData}, {1'b1, res[7:0]});
    else
      check(!fileWrEn, req, fileWrEn, 0);
    @(posedge clk); #1;
    check(workReg == nw[7:0], req, workReg, nw);
    check(statusReg == ns[7:0], req, statusReg, ns);
    mW = nw;
    mS = ns;
  endtask

  task automatic idle(input int fv, input string req);
    @(negedge clk);
    opValid = 1'b0; opCode = 4'(fv % 16); fileData = fv[7:0]; litData = fv[7:0];
    destIsFile = fv[0]; fileIsStatus = fv[1]; srcIsLiteral = fv[2];
    #1;
    check(!fileWrEn, req, fileWrEn, 0);
    @(posedge clk); #1;
    check(workReg == mW[7:0], req, workReg, mW);
    check(statusReg == mS[7:0], req, statusReg, mS);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    aluOp_e zOps[8] = '{OP_AND, OP_IOR, OP_XOR, OP_COM, OP_INC, OP_DEC, OP_MOVF, OP_CLR};
    rstN = 1'b0; opValid = 1'b0; opCode = 4'd0; srcIsLiteral = 1'b0;
    fileData = 8'h00; litData = 8'h00; bitSel = 3'd0; destIsFile = 1'b0; fileIsStatus = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(workReg == 8'h00, "R1", workReg, 0);
    check(statusReg == 8'h18, "R1", statusReg, 'h18);
    @(negedge clk);
    rstN = 1'b1;

    // R2: add over every operand, W spread over the byte range
    for (int wv = 0; wv < 256; wv += 5) begin
      step(OP_MOVF, 1, 0, wv, 0, 0, 0, "R12");
      for (int b = 0; b < 256; b++) step(OP_ADD, 0, b, ~b & 255, 0, 1, 0, "R2");
    end

    // R3: subtract over every operand from the immediate path
    for (int wv = 0; wv < 256; wv += 3) begin
      step(OP_MOVF, 1, 0, wv, 0, 0, 0, "R12");
      for (int b = 0; b < 256; b++) step(OP_SUB, 1, (b * 7) & 255, b, 0, 1, 0, "R3");
    end

    // R12: same inputs, opposite operand choice
    step(OP_MOVF, 1, 0, 'h0F, 0, 0, 0, "R12");
    step(OP_ADD, 1, 'hF0, 'h01, 0, 1, 0, "R12");
    step(OP_ADD, 0, 'hF0, 'h01, 0, 1, 0, "R12");

    // R4: preset C and DC to 1, then Z-only operations
    step(OP_MOVF, 1, 0, 'h03, 0, 0, 0, "R9");
    step(OP_MOVW, 0, 0, 0, 0, 1, 1, "R9");
    step(OP_MOVF, 1, 0, 'h5A, 0, 0, 0, "R4");
    foreach (zOps[i])
      for (int b = 0; b < 256; b++) step(zOps[i], 0, b, 0, 0, 1, 0, "R4");
    step(OP_AND, 1, 0, 'hA5, 0, 0, 0, "R7");
    step(OP_IOR, 1, 0, 'h3C, 0, 0, 0, "R7");
    step(OP_XOR, 0, 'h3C, 0, 0, 0, 0, "R7");
    step(OP_INC, 0, 'hFF, 0, 0, 0, 0, "R7");

    // R5: rotates with the carry chained from step to step
    for (int b = 0; b < 256; b++) step(OP_RLC, 0, b, 0, 0, 1, 0, "R5");
    for (int b = 0; b < 256; b++) step(OP_RRC, 0, (b * 37) & 255, 0, 0, 1, 0, "R5");
    step(OP_RLC, 0, 'h80, 0, 0, 0, 0, "R5");
    step(OP_RRC, 0, 'h01, 0, 0, 0, 0, "R5");

    // R6: flag-free operations over operands and bit numbers
    for (int b = 0; b < 256; b++) step(OP_SWAP, 0, b, 0, 0, 1, 0, "R6");
    for (int bs = 0; bs < 8; bs++)
      for (int b = 0; b < 256; b += 17) begin
        step(OP_BSET, 0, b, 0, bs, 1, 0, "R6");
        step(OP_BCLR, 0, b, 0, bs, 1, 0, "R6");
      end
    step(OP_MOVF, 1, 0, 'hC3, 0, 0, 0, "R6");
    step(OP_MOVW, 0, 0, 0, 0, 1, 0, "R6");

    // R8: flag register as target of flag-updating operations
    step(OP_MOVF, 1, 0, 'h00, 0, 0, 0, "R8");
    step(OP_MOVW, 0, 0, 0, 0, 1, 1, "R10");
    step(OP_CLR, 0, 0, 0, 0, 1, 1, "R8");
    step(OP_MOVF, 1, 0, 'hE3, 0, 0, 0, "R8");
    step(OP_MOVW, 0, 0, 0, 0, 1, 1, "R9");
    step(OP_CLR, 0, 0, 0, 0, 1, 1, "R8");
    step(OP_MOVF, 1, 0, 'hF0, 0, 0, 0, "R8");
    step(OP_ADD, 0, 'h20, 0, 0, 1, 1, "R8");
    step(OP_SUB, 0, 'h10, 0, 0, 1, 1, "R8");
    step(OP_AND, 0, 'h0F, 0, 0, 1, 1, "R8");
    step(OP_RLC, 0, 'hFF, 0, 0, 1, 1, "R8");
    step(OP_COM, 0, 'h00, 0, 0, 1, 1, "R8");

    // R9/R10: plain data into the flag register
    step(OP_MOVF, 1, 0, 'hFF, 0, 0, 0, "R9");
    step(OP_MOVW, 0, 0, 0, 0, 1, 1, "R9");
    step(OP_MOVF, 1, 0, 'h00, 0, 0, 0, "R10");
    step(OP_MOVW, 0, 0, 0, 0, 1, 1, "R10");
    step(OP_SWAP, 0, 'h5A, 0, 0, 1, 1, "R9");
    step(OP_BCLR, 0, 'hFF, 0, 4, 1, 1, "R10");
    step(OP_BSET, 0, 'h00, 0, 2, 1, 1, "R9");

    // R11: idle cycles with busy inputs
    for (int k = 0; k < 32; k++) idle((k * 29 + 3) & 255, "R11");

    @(negedge clk);
    opValid = 1'b0;
    summary();
  end
endmodule